// File: doc/BRIEF.md
# 64-bit Master Write Lane Adapter

This block runs the data phases of a burst write issued by an initiator that can move 64 bits per data phase. Its source is a queue of 32-bit words, each carrying its own active-low byte enables. The queue shows its head word and the word behind it. The block tells the queue how many words to drop after each completed transfer. Software or a sequencer supplies a start pulse, a bus command, a start address and a burst length in words. The block then runs one address phase and as many data phases as the burst needs.

The 64-bit request is raised together with the frame. In the first data phase the block drives two dwords at once, one on each half of the bus. If the target answers the 64-bit request, each transfer retires two words. If the target declines, the block retires only the lower dword and moves the next word down to the lower lanes. It then finishes the burst one dword per phase and disables the upper lanes. Target wait states freeze the lanes. The frame is released for the final data phase. The initiator ready signal stays asserted until that last transfer completes.

Top module: `wide_wr_master`

## Requirements
- R1: After reset `frame_n`, `req64_n` and `irdy_n` are high, `busy` is low, `q_adv` is 0 and `ad_hi_oe` is 0.
- R2: When `start` is sampled high while idle with a nonzero `burst_len`, the next cycle is the address phase: `frame_n` and `req64_n` are low, `irdy_n` is high, `ad[31:0]` equals `addr` and `cbe_n[3:0]` equals `cmd`. `req64_n` matches `frame_n` at all times.
- R3: In the first data phase the head word and its enables are on `ad[31:0]`/`cbe_n[3:0]`, and the second word and its enables are on `ad[63:32]`/`cbe_n[7:4]`, with `ad_hi_oe` high.
- R4: A transfer is a clock edge with `irdy_n`, `trdy_n` and `devsel_n` all low. When the target has `ack64_n` low, each transfer with at least two words left retires two words (`q_adv` = 2).
- R5: When the target has `ack64_n` high at the first `devsel_n`-low sample, each transfer retires one word (`q_adv` = 1). The following word appears on the lower lanes. For the rest of the burst `ad_hi_oe` is 0, `ad[63:32]` is 0 and `cbe_n[7:4]` is 4'hF.
- R6: During a wait state (`irdy_n` low, `trdy_n` high) `q_adv` is 0, and `ad[31:0]`, `cbe_n[3:0]` and `irdy_n` hold into the next cycle.
- R7: `frame_n` is low in every data phase except the final one and high in the final one. The cycle after the final transfer has `frame_n` and `irdy_n` high and `busy` low.
- R8: In 64-bit mode, a final phase with a single word left drives `cbe_n[7:4]` = 4'hF and `ad[63:32]` = 0, with `ad_hi_oe` high, and retires one word.
- R9: While exactly two words remain and `devsel_n` has not yet been seen low, `irdy_n` is held high. This keeps the frame from ending before the transfer width is known.
- R10: `start` is ignored while `busy` is high. A `start` with `burst_len` of 0 is also ignored; `busy` and `frame_n` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst (sampled when idle) |
| cmd | input | 4 | Bus command for the address phase |
| addr | input | 32 | Burst start address |
| burst_len | input | LEN_W | Number of 32-bit words to write |
| q_data0 | input | 32 | Queue head word |
| q_be0_n | input | 4 | Byte enables of head word, active low |
| q_data1 | input | 32 | Word behind the head |
| q_be1_n | input | 4 | Byte enables of that word, active low |
| q_adv | output | 2 | Words to drop from the queue at this edge |
| busy | output | 1 | Burst in progress |
| frame_n | output | 1 | Frame, active low |
| req64_n | output | 1 | 64-bit transfer request, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| ad | output | 64 | Address/data lanes |
| ad_hi_oe | output | 1 | Upper lanes carry valid drive |
| cbe_n | output | 8 | Command / byte enables, active low |
| devsel_n | input | 1 | Target device select, active low |
| trdy_n | input | 1 | Target ready, active low |
| ack64_n | input | 1 | Target 64-bit acknowledge, active low |

## Verification
The address phase is due one cycle after the edge that samples `start`, and the first data phase one cycle later. The bench samples each of these at the falling edge inside the expected cycle. Lane, enable and `q_adv` values follow the queue head and the target inputs within the same cycle. They are compared at the falling edge just before the rising edge that completes the transfer. A scoreboard queue filled by the driver holds the expected lane contents and word count for every transfer, in order. The idle state is due in the cycle after the final transfer and is checked at that cycle's falling edge. Wait-state stability is checked by comparing the lanes against the previous falling edge.

// File: rtl/wide_wr_master.sv
module wide_wr_master #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       cmd,
  input  logic [31:0]      addr,
  input  logic [LEN_W-1:0] burst_len,
  input  logic [31:0]      q_data0,
  input  logic [3:0]       q_be0_n,
  input  logic [31:0]      q_data1,
  input  logic [3:0]       q_be1_n,
  output logic [1:0]       q_adv,
  output logic             busy,
  output logic             frame_n,
  output logic             req64_n,
  output logic             irdy_n,
  output logic [63:0]      ad,
  output logic             ad_hi_oe,
  output logic [7:0]       cbe_n,
  input  logic             devsel_n,
  input  logic             trdy_n,
  input  logic             ack64_n
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;

  st_t             state;
  logic [LEN_W-1:0] rem;
  logic            seen;
  logic            wide;

  logic dphase, aphase, two_left, hold, last, xfer, wide_now, take2, hi_on;

  assign aphase   = state == S_ADDR;
  assign dphase   = state == S_DATA;
  assign two_left = rem >= LEN_W'(2);
  assign hold     = dphase && !seen && rem == LEN_W'(2);
  assign last     = rem == LEN_W'(1) || (seen && wide && rem == LEN_W'(2));

  assign irdy_n   = !(dphase && !hold);
  assign frame_n  = !(aphase || (dphase && !last));
  assign req64_n  = frame_n;
  assign busy     = state != S_IDLE;

  assign xfer     = !irdy_n && !trdy_n && !devsel_n;
  assign wide_now = seen ? wide : !ack64_n;
  assign take2    = xfer && wide_now && two_left;
  assign q_adv    = take2 ? 2'd2 : {1'b0, xfer};

  assign hi_on    = dphase && (!seen || wide);
  assign ad_hi_oe = hi_on;

  assign ad[31:0]    = aphase ? addr : (dphase ? q_data0 : 32'd0);
  assign ad[63:32]   = (hi_on && two_left) ? q_data1 : 32'd0;
  assign cbe_n[3:0]  = aphase ? cmd : (dphase ? q_be0_n : 4'hF);
  assign cbe_n[7:4]  = (hi_on && two_left) ? q_be1_n : 4'hF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      rem   <= '0;
      seen  <= 1'b0;
      wide  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start && burst_len != '0) begin
          state <= S_ADDR;
          rem   <= burst_len;
          seen  <= 1'b0;
          wide  <= 1'b1;
        end
        S_ADDR: state <= S_DATA;
        S_DATA: begin
          if (!devsel_n && !seen) begin
            seen <= 1'b1;
            wide <= !ack64_n;
          end
          if (xfer) begin
            rem <= rem - (take2 ? LEN_W'(2) : LEN_W'(1));
            if (last) state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_frame_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> !req64_n && irdy_n && $past(state) == S_IDLE);

  assert_pair_needs_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_adv == 2'd2) |-> !ack64_n && !trdy_n);

  assert_fallback_lower_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dphase && xfer && ack64_n && !last) |=> (!ad_hi_oe && cbe_n[7:4] == 4'hF));

  assert_wait_holds_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && trdy_n) |=> (!irdy_n && $stable(ad[31:0]) && $stable(cbe_n[3:0])));

  assert_frame_stays_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dphase && frame_n && !xfer) |=> frame_n);

  assert_end_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && frame_n) |=> (frame_n && irdy_n && !busy));

endmodule

// File: tb/wide_wr_master_tb.sv
module wide_wr_master_tb;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] cmd = 4'h7;
  logic [31:0] addr = 32'h0000_1000;
  logic [LEN_W-1:0] burst_len = '0;
  logic [31:0] q_data0, q_data1;
  logic [3:0] q_be0_n, q_be1_n;
  logic [1:0] q_adv;
  logic busy, frame_n, req64_n, irdy_n, ad_hi_oe;
  logic [63:0] ad;
  logic [7:0] cbe_n;
  logic devsel_n = 1'b1, trdy_n = 1'b1, ack64_n = 1'b1;

  int vectors = 0;
  int miscompares = 0;

  logic [31:0] md [0:63];
  logic [3:0]  mb [0:63];
  logic [5:0]  hp = '0;
  logic [75:0] expq [$];

  bit t_ack = 1'b0;
  int t_dly = 1;
  logic [7:0] t_wmask = '0;

  always #4 clk = ~clk;

  assign q_data0 = md[hp];
  assign q_be0_n = mb[hp];
  assign q_data1 = md[hp + 6'd1];
  assign q_be1_n = mb[hp + 6'd1];

  always @(posedge clk) if (rst_n) hp <= hp + {4'd0, q_adv};

  wide_wr_master #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr),
    .burst_len(burst_len), .q_data0(q_data0), .q_be0_n(q_be0_n),
    .q_data1(q_data1), .q_be1_n(q_be1_n), .q_adv(q_adv), .busy(busy),
    .frame_n(frame_n), .req64_n(req64_n), .irdy_n(irdy_n), .ad(ad),
    .ad_hi_oe(ad_hi_oe), .cbe_n(cbe_n), .devsel_n(devsel_n),
    .trdy_n(trdy_n), .ack64_n(ack64_n));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // target model: responds after t_dly cycles, waits where t_wmask bit is set
  initial begin
    bit active = 1'b0;
    int k = 0;
    forever begin
      @(posedge clk); #1;
      if (!active) begin
        if (busy && !frame_n && irdy_n) begin active = 1'b1; k = 0; end
      end else if (!busy) active = 1'b0;
      else k++;
      devsel_n = !(active && k >= t_dly);
      trdy_n   = !(active && k >= t_dly && !t_wmask[k % 8]);
      ack64_n  = !(active && k >= t_dly && t_ack);
    end
  end

  // monitor: pops scoreboard on each transfer, checks wait states
  initial begin
    bit prev_wait = 1'b0;
    logic [31:0] prev_lo = '0;
    logic [3:0] prev_be = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_wait) begin
          chk(ad[31:0] == prev_lo, "R6 lower data held", {32'd0, ad[31:0]}, {32'd0, prev_lo});
          chk(cbe_n[3:0] == prev_be && !irdy_n, "R6 enables/irdy held", {59'd0, irdy_n, cbe_n[3:0]}, {60'd0, prev_be});
        end
        if (busy && !irdy_n && trdy_n)
          chk(q_adv == 2'd0, "R6 no pop in wait", {62'd0, q_adv}, 64'd0);
        if (!irdy_n && !trdy_n && !devsel_n) begin
          if (expq.size() == 0) chk(1'b0, "R4/R5 unexpected transfer", {62'd0, q_adv}, 64'd0);
          else begin
            logic [75:0] e;
            e = expq.pop_front();
            chk(q_adv == e[75:74], "R4/R5 words per transfer", {62'd0, q_adv}, {62'd0, e[75:74]});
            chk(ad[31:0] == e[71:40] && cbe_n[3:0] == e[39:36], "R3 lower lanes",
                {28'd0, cbe_n[3:0], ad[31:0]}, {28'd0, e[39:36], e[71:40]});
            chk(frame_n == (expq.size() == 0), "R7 frame on final phase",
                {63'd0, frame_n}, {63'd0, expq.size() == 0});
            if (e[73:72] == 2'd1)
              chk(ad_hi_oe && ad[63:32] == e[35:4] && cbe_n[7:4] == e[3:0],
                  e[75:74] == 2'd1 ? "R8 odd final upper lanes" : "R4 upper lanes",
                  {27'd0, ad_hi_oe, cbe_n[7:4], ad[63:32]}, {27'd1, e[3:0], e[35:4]});
            else if (e[73:72] == 2'd2)
              chk(!ad_hi_oe && ad[63:32] == 32'd0 && cbe_n[7:4] == 4'hF, "R5 upper lanes off",
                  {27'd0, ad_hi_oe, cbe_n[7:4], ad[63:32]}, {28'd0, 4'hF, 32'd0});
          end
        end
        prev_wait = busy && !irdy_n && trdy_n;
        prev_lo = ad[31:0];
        prev_be = cbe_n[3:0];
      end
    end
  end

  task automatic run_burst(input int len, input bit ack, input int dly, input logic [7:0] wm, input bit restart);
    logic [5:0] base;
    base = hp;
    for (int i = 0; i < len; i++) begin
      md[base + 6'(i)] = 32'hA000_0000 + 32'(len * 256 + i * 17) + {31'd0, ack};
      mb[base + 6'(i)] = 4'(i * 5 + 1);
    end
    if (ack) begin
      for (int i = 0; i < len; i += 2) begin
        if (i + 1 < len) expq.push_back({2'd2, 2'd1, md[base + 6'(i)], mb[base + 6'(i)], md[base + 6'(i + 1)], mb[base + 6'(i + 1)]});
        else             expq.push_back({2'd1, 2'd1, md[base + 6'(i)], mb[base + 6'(i)], 32'd0, 4'hF});
      end
    end else begin
      for (int i = 0; i < len; i++)
        expq.push_back({2'd1, (i == 0) ? 2'd0 : 2'd2, md[base + 6'(i)], mb[base + 6'(i)], 32'd0, 4'hF});
    end
    t_ack = ack; t_dly = dly; t_wmask = wm;
    burst_len = LEN_W'(len);
    addr = 32'h0000_1000 + 32'(len * 64);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    chk(!frame_n && !req64_n && irdy_n, "R2 address phase controls", {61'd0, frame_n, req64_n, irdy_n}, 64'd1);
    chk(ad[31:0] == addr && cbe_n[3:0] == cmd, "R2 address and command",
        {28'd0, cbe_n[3:0], ad[31:0]}, {28'd0, cmd, addr});
    @(negedge clk);
    chk(ad[31:0] == md[base] && cbe_n[3:0] == mb[base] && ad_hi_oe, "R3 first phase lower",
        {27'd0, ad_hi_oe, cbe_n[3:0], ad[31:0]}, {27'd1, mb[base], md[base]});
    if (len >= 2)
      chk(ad[63:32] == md[base + 6'd1] && cbe_n[7:4] == mb[base + 6'd1], "R3 first phase upper",
          {28'd0, cbe_n[7:4], ad[63:32]}, {28'd0, mb[base + 6'd1], md[base + 6'd1]});
    else
      chk(cbe_n[7:4] == 4'hF && frame_n, "R8 single word upper off", {59'd0, frame_n, cbe_n[7:4]}, {59'd1, 4'hF});
    chk(irdy_n == (len == 2), "R9 irdy in first phase", {63'd0, irdy_n}, {63'd0, len == 2});
    chk(req64_n == frame_n, "R2 req64 follows frame", {63'd0, req64_n}, {63'd0, frame_n});
    if (restart) begin
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    while (busy) @(negedge clk);
    chk(frame_n && irdy_n && q_adv == 2'd0, "R7 idle after final transfer", {61'd0, frame_n, irdy_n, q_adv == 2'd0}, 64'd7);
    chk(expq.size() == 0 && hp == base + 6'(len), "R4/R5 queue fully consumed", {58'd0, hp}, {58'd0, base + 6'(len)});
    if (restart) begin
      @(negedge clk);
      chk(!busy && frame_n, "R10 start during burst ignored", {62'd0, busy, frame_n}, 64'd1);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(frame_n && req64_n && irdy_n && !busy && q_adv == 2'd0 && !ad_hi_oe, "R1 reset state",
        {58'd0, frame_n, req64_n, irdy_n, busy, q_adv == 2'd0, ad_hi_oe}, 64'h3A);
    run_burst(6, 1'b1, 1, 8'h00, 1'b0);
    run_burst(5, 1'b1, 2, 8'h04, 1'b0);
    run_burst(5, 1'b0, 1, 8'h00, 1'b0);
    run_burst(4, 1'b0, 3, 8'h12, 1'b0);
    run_burst(2, 1'b1, 1, 8'h00, 1'b0);
    run_burst(2, 1'b0, 2, 8'h00, 1'b0);
    run_burst(1, 1'b1, 1, 8'h00, 1'b0);
    run_burst(1, 1'b0, 2, 8'h08, 1'b0);
    run_burst(7, 1'b1, 1, 8'h22, 1'b0);
    run_burst(5, 1'b1, 1, 8'h00, 1'b1);
    burst_len = '0;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    chk(!busy && frame_n, "R10 zero length ignored", {62'd0, busy, frame_n}, 64'd1);
    @(negedge clk);
    chk(!busy && frame_n && irdy_n, "R10 still idle", {61'd0, busy, frame_n, irdy_n}, 64'd3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog R7: burst never ended, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule